// File: doc/BRIEF.md
# Line Ownership Directory Controller

This block sits beside main memory and remembers, for every 32-byte line, whether write privilege for that line has been handed out. While a line is marked owned, the valid copy lives in a requester's write-back cache or I/O buffer, and memory must not return its own stale copy. Three requesters feed commands into the block: a CPU, an I/O adapter and the memory controller itself. Each requester has its own bounded command queue. A round-robin arbiter picks which queue is served next.

A state machine handles one command at a time. It reads the directory word that covers the line and corrects or flags any ECC error. It then decides the response and writes the updated, re-encoded word back. The response is presented for one cycle on a shared response port. The directory is a private array of 8-bit words, one bit per line. Each word is stored with a 5-bit single-error-correct, double-error-detect check, so a stored codeword is 13 bits. A fault-injection port can flip any codeword bits, so that the ECC path can be exercised.

States:
- S_IDLE: waits for work. It leaves for S_LOOKUP in any cycle where at least one queue is non-empty, and in that cycle it pops the granted queue.
- S_LOOKUP: decodes the directory word, decides the response and writes the word back. It always moves on to S_RESP.
- S_RESP: drives the response for one cycle. It always returns to S_IDLE.

Top module: `own_dir_ctrl`

## Requirements
- R1: After reset, every line reads as unowned. All three `req_ready` bits are 1 and `rsp_valid` is 0.
- R2: Command encodings are 0 = plain read, 1 = read for ownership (RFO), 2 = write-back, 3 = remove write privilege. An RFO to an unowned line answers code 0 (OK) and marks the line owned.
- R3: A plain read or an RFO to an owned line answers code 1 (RETRY) and leaves the line owned.
- R4: A plain read to an unowned line answers OK and leaves the line unowned.
- R5: A write-back or a remove-write-privilege command answers OK and leaves the line unowned, whatever its earlier state.
- R6: Each accepted command yields exactly one response, a single-cycle `rsp_valid` pulse. The pulse carries the requester index (0 CPU, 1 I/O, 2 memory controller) and the line address. Within line address bits, bits [LINE_W-1:3] pick the directory word and bits [2:0] pick the bit in that word.
- R7: When several queues hold commands, service rotates round-robin. It starts with the requester after the one served last; after reset, requester 0 is first.
- R8: Each queue holds QDEPTH commands (a power of two). `req_ready` drops while the queue is full, and no accepted command is lost or repeated.
- R9: A single flipped codeword bit is corrected on lookup. The response is computed from the corrected word and carries `rsp_fixed` = 1. The corrected word is written back, so the next access to that word has `rsp_fixed` = 0.
- R10: Two flipped bits in one codeword give code 2 (ERR) with `dbl_err` = 1 and leave the word unwritten, so later accesses to that word also give ERR. Other words are unaffected.
- R11: While `inj_en` is 1, the codeword at `inj_word` is XORed with `inj_mask` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 3 | Per-requester command valid |
| req_cmd | input | 6 | Per-requester 2-bit command, requester i in bits [2i+1:2i] |
| req_line | input | 3*LINE_W | Per-requester line address, requester i in slice i |
| req_ready | output | 3 | Per-requester queue not full |
| inj_en | input | 1 | Fault-injection strobe |
| inj_word | input | LINE_W-3 | Directory word to corrupt |
| inj_mask | input | 13 | Codeword bits to flip |
| rsp_valid | output | 1 | Response pulse |
| rsp_id | output | 2 | Requester the response belongs to |
| rsp_line | output | LINE_W | Line address of the answered command |
| rsp_code | output | 2 | 0 OK, 1 RETRY, 2 ERR |
| rsp_fixed | output | 1 | A single-bit directory error was corrected |
| dbl_err | output | 1 | An uncorrectable directory error was found |

## Verification
Lines are drawn from a narrow window so that commands from different requesters collide on the same lines and words. This randomized traffic separates a wrong ownership transition from a wrong response code. Simultaneous bursts from all three requesters show whether the rotation order is right. A requester held valid for many cycles shows whether backpressure loses or repeats commands. Single-bit flips at every codeword position, including the check bits and the overall parity bit, show whether correction works and whether the fixed word is written back. A two-bit flip shows whether the error is detected and whether the word is left alone afterwards.

// File: rtl/own_dir_pkg.sv
package own_dir_pkg;
    localparam int NREQ = 3;
    localparam int DW   = 8;
    localparam int CW   = 13;

    typedef enum logic [1:0] {CMD_RD = 2'd0, CMD_RFO = 2'd1, CMD_WB = 2'd2, CMD_RWP = 2'd3} cmd_e;
    typedef enum logic [1:0] {RSP_OK = 2'd0, RSP_RETRY = 2'd1, RSP_ERR = 2'd2} rsp_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          fixed;
        logic          dbl;
    } dec_t;

    // Hamming positions 1..12 (powers of two hold checks), position 0 holds overall parity
    function automatic logic [CW-1:0] secded_enc(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p < CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < 4; b++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p < CW; p++) begin
                if (((p >> b) & 1) == 1) par = par ^ c[p];
            end
            c[1 << b] = par;
        end
        c[0] = ^c[CW-1:1];
        return c;
    endfunction

    function automatic dec_t secded_dec(input logic [CW-1:0] c);
        dec_t r;
        logic [3:0] s;
        logic [CW-1:0] cc;
        int k;
        s = '0;
        for (int p = 1; p < CW; p++) begin
            if (c[p]) s = s ^ 4'(p);
        end
        cc = c;
        r.fixed = 1'b0;
        r.dbl   = 1'b0;
        if (^c) begin
            if (int'(s) < CW) begin
                cc[s] = ~cc[s];
                r.fixed = 1'b1;
            end else begin
                r.dbl = 1'b1;
            end
        end else if (s != 4'd0) begin
            r.dbl = 1'b1;
        end
        k = 0;
        r.data = '0;
        for (int p = 1; p < CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                r.data[k] = cc[p];
                k++;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/own_cmd_fifo.sv
module own_cmd_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;

    assign full  = (cnt_q == (AW+1)'(DEPTH));
    assign empty = (cnt_q == '0);
    assign dout  = mem[rp_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem[wp_q] <= din;
                wp_q      <= wp_q + 1'b1;
            end
            if (pop) rp_q <= rp_q + 1'b1;
            if (push && !pop) cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // R8: the state machine never pops a queue that is empty
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
    // R8: a push is never taken while the queue is full
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n) full |-> !push);
endmodule

// File: rtl/own_rr_arb.sv
module own_rr_arb #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] last_q;

    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int off = 1; off <= N; off++) begin
            int idx;
            idx = (int'(last_q) + off) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= IW'(N - 1);
        end else if (adv) begin
            for (int i = 0; i < N; i++) begin
                if (gnt[i]) last_q <= IW'(i);
            end
        end
    end

    // R7: at most one requester holds the grant
    assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
    // R7: a grant only goes to a requester that is asking
    assert_grant_req_R7: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);
endmodule

// File: rtl/own_dir_ctrl.sv
module own_dir_ctrl
    import own_dir_pkg::*;
#(
    parameter int LINE_W = 8,
    parameter int QDEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREQ-1:0]          req_valid,
    input  logic [2*NREQ-1:0]        req_cmd,
    input  logic [NREQ*LINE_W-1:0]   req_line,
    output logic [NREQ-1:0]          req_ready,
    input  logic                     inj_en,
    input  logic [LINE_W-4:0]        inj_word,
    input  logic [CW-1:0]            inj_mask,
    output logic                     rsp_valid,
    output logic [1:0]               rsp_id,
    output logic [LINE_W-1:0]        rsp_line,
    output logic [1:0]               rsp_code,
    output logic                     rsp_fixed,
    output logic                     dbl_err
);
    localparam int WAW    = LINE_W - 3;
    localparam int NWORDS = 1 << WAW;
    localparam int FW     = 2 + LINE_W;

    typedef enum logic [1:0] {S_IDLE = 2'd0, S_LOOKUP = 2'd1, S_RESP = 2'd2} state_e;

    state_e state_q, state_d;

    logic [NREQ-1:0] q_full, q_empty, q_pop, gnt;
    logic [FW-1:0]   q_dout [NREQ];

    for (genvar g = 0; g < NREQ; g++) begin : g_queue
        own_cmd_fifo #(.W(FW), .DEPTH(QDEPTH)) u_q (
            .clk  (clk),
            .rst_n(rst_n),
            .push (req_valid[g] && !q_full[g]),
            .din  ({req_cmd[2*g +: 2], req_line[g*LINE_W +: LINE_W]}),
            .pop  (q_pop[g]),
            .dout (q_dout[g]),
            .full (q_full[g]),
            .empty(q_empty[g])
        );
        assign req_ready[g] = !q_full[g];
    end

    own_rr_arb #(.N(NREQ)) u_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (~q_empty),
        .adv  (state_q == S_IDLE),
        .gnt  (gnt)
    );

    logic [CW-1:0]     store [NWORDS];
    logic [1:0]        cur_id;
    cmd_e              cur_cmd;
    logic [LINE_W-1:0] cur_line;
    logic [WAW-1:0]    cur_word;
    logic [2:0]        cur_bit;
    dec_t              dec;
    logic [DW-1:0]     new_data;
    rsp_e              code_d;
    logic              wr_en;
    logic [1:0]        rsp_code_q;
    logic              fixed_q, dbl_q;

    assign cur_word = cur_line[LINE_W-1:3];
    assign cur_bit  = cur_line[2:0];
    assign dec      = secded_dec(store[cur_word]);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and control outputs
    always_comb begin
        state_d   = state_q;
        q_pop     = '0;
        wr_en     = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                q_pop = gnt;
                if (|gnt) state_d = S_LOOKUP;
            end
            S_LOOKUP: begin
                wr_en   = !dec.dbl;
                state_d = S_RESP;
            end
            S_RESP: begin
                rsp_valid = 1'b1;
                state_d   = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Ownership decision on the corrected word
    always_comb begin
        new_data = dec.data;
        code_d   = RSP_OK;
        if (dec.dbl) begin
            code_d = RSP_ERR;
        end else begin
            unique case (cur_cmd)
                CMD_RD:  code_d = dec.data[cur_bit] ? RSP_RETRY : RSP_OK;
                CMD_RFO: begin
                    if (dec.data[cur_bit]) code_d = RSP_RETRY;
                    else new_data[cur_bit] = 1'b1;
                end
                CMD_WB, CMD_RWP: new_data[cur_bit] = 1'b0;
                default: code_d = RSP_OK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_id     <= '0;
            cur_cmd    <= CMD_RD;
            cur_line   <= '0;
            rsp_code_q <= '0;
            fixed_q    <= 1'b0;
            dbl_q      <= 1'b0;
        end else begin
            if (state_q == S_IDLE) begin
                for (int i = 0; i < NREQ; i++) begin
                    if (gnt[i]) begin
                        cur_id   <= 2'(i);
                        cur_cmd  <= cmd_e'(q_dout[i][FW-1 -: 2]);
                        cur_line <= q_dout[i][LINE_W-1:0];
                    end
                end
            end
            if (state_q == S_LOOKUP) begin
                rsp_code_q <= code_d;
                fixed_q    <= dec.fixed;
                dbl_q      <= dec.dbl;
            end
        end
    end

    // Directory array with fault injection; the state machine write wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NWORDS; w++) store[w] <= secded_enc('0);
        end else begin
            if (inj_en) store[inj_word] <= store[inj_word] ^ inj_mask;
            if (wr_en)  store[cur_word] <= secded_enc(new_data);
        end
    end

    assign rsp_id    = cur_id;
    assign rsp_line  = cur_line;
    assign rsp_code  = rsp_valid ? rsp_code_q : 2'd0;
    assign rsp_fixed = rsp_valid && fixed_q;
    assign dbl_err   = rsp_valid && dbl_q;

    // R6: a response lasts exactly one cycle
    assert_one_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid);
    // R10: an uncorrectable error is reported with the ERR code
    assert_dbl_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_err |-> (rsp_code == 2'd2));
    // R9: a word written back by the lookup decodes clean afterwards
    assert_clean_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RESP && $past(wr_en) && !$past(inj_en)) |-> (!dec.fixed && !dec.dbl));
    // R3: a RETRY never comes with an ECC error flag
    assert_retry_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd1) |-> !dbl_err);
endmodule

// File: tb/own_dir_ctrl_tb.sv
module own_dir_ctrl_tb;
    localparam int LINE_W = 8;
    localparam int QDEPTH = 4;
    localparam int NW     = 1 << (LINE_W - 3);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [2:0]            req_valid = '0;
    logic [5:0]            req_cmd = '0;
    logic [3*LINE_W-1:0]   req_line = '0;
    logic [2:0]            req_ready;
    logic                  inj_en = 1'b0;
    logic [LINE_W-4:0]     inj_word = '0;
    logic [12:0]           inj_mask = '0;
    logic                  rsp_valid;
    logic [1:0]            rsp_id;
    logic [LINE_W-1:0]     rsp_line;
    logic [1:0]            rsp_code;
    logic                  rsp_fixed;
    logic                  dbl_err;

    own_dir_ctrl #(.LINE_W(LINE_W), .QDEPTH(QDEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_line(req_line), .req_ready(req_ready), .inj_en(inj_en),
        .inj_word(inj_word), .inj_mask(inj_mask), .rsp_valid(rsp_valid),
        .rsp_id(rsp_id), .rsp_line(rsp_line), .rsp_code(rsp_code),
        .rsp_fixed(rsp_fixed), .dbl_err(dbl_err)
    );

    always #5 clk = ~clk;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    int  cyc = 0;
    bit  own [1 << LINE_W];
    int  wst [NW];        // 0 clean, 1 single flip pending, 2 double flip
    int  last_id = 2;
    int unsigned seed = 32'd1234;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int cmd, input bit owned, input int ws);
        if (ws == 2) return 2;
        if (cmd == 0 || cmd == 1) return owned ? 1 : 0;
        return 0;
    endfunction

    function automatic string req_of(input int cmd, input bit owned, input int ws);
        if (ws == 2) return "R10";
        if (ws == 1) return "R9";
        if ((cmd == 0 || cmd == 1) && owned) return "R3";
        if (cmd == 1) return "R2";
        if (cmd == 0) return "R4";
        return "R5";
    endfunction

    task automatic model_apply(input int cmd, input int line);
        int w;
        w = line >> 3;
        if (wst[w] == 2) return;
        wst[w] = 0;
        if (cmd == 1 && !own[line]) own[line] = 1;
        else if (cmd >= 2) own[line] = 0;
    endtask

    task automatic wait_rsp(output bit got);
        got = 0;
        for (int i = 0; i < 40 && !got; i++) begin
            @(negedge clk);
            if (rsp_valid) got = 1;
        end
    endtask

    task automatic do_op(input int id, input int cmd, input int line);
        bit got;
        int ec, w;
        string rq;
        w  = line >> 3;
        ec = exp_code(cmd, own[line], wst[w]);
        rq = req_of(cmd, own[line], wst[w]);
        req_valid[id] = 1'b1;
        req_cmd[id*2 +: 2] = 2'(cmd);
        req_line[id*LINE_W +: LINE_W] = LINE_W'(line);
        @(negedge clk);
        req_valid = '0;
        wait_rsp(got);
        chk(got, "R6 response present", int'(got), 1);
        if (got) begin
            chk(int'(rsp_code) == ec, rq, int'(rsp_code), ec);
            chk(int'(rsp_id) == id && int'(rsp_line) == line, "R6 id/line",
                int'(rsp_id) * 1000 + int'(rsp_line), id * 1000 + line);
            chk(rsp_fixed == (wst[w] == 1), "R9 fixed flag", int'(rsp_fixed), int'(wst[w] == 1));
            chk(dbl_err == (wst[w] == 2), "R10 dbl flag", int'(dbl_err), int'(wst[w] == 2));
            @(negedge clk);
            chk(!rsp_valid, "R6 single pulse", int'(rsp_valid), 0);
        end
        model_apply(cmd, line);
        last_id = id;
    endtask

    task automatic inject(input int w, input logic [12:0] m);
        inj_en = 1'b1;
        inj_word = (LINE_W-3)'(w);
        inj_mask = m;
        @(negedge clk);
        inj_en = 1'b0;
        inj_mask = '0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << LINE_W); i++) own[i] = 0;
        for (int i = 0; i < NW; i++) wst[i] = 0;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 3'b111, "R1 ready", int'(req_ready), 7);
        chk(!rsp_valid, "R1 no response", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 3'b111 && !rsp_valid, "R1 after release", int'(req_ready), 7);

        // Directed: R2 RFO sets, R3 retry, R5 clears, R4 plain read
        do_op(0, 1, 5);
        do_op(1, 1, 5);
        do_op(2, 0, 5);
        do_op(1, 2, 5);
        do_op(0, 0, 5);
        do_op(2, 3, 6);
        do_op(2, 1, 6);
        do_op(0, 3, 6);
        do_op(1, 1, 6);

        // R9: single flip at every codeword position, word 2
        for (int p = 0; p < 13; p++) begin
            inject(2, 13'(1) << p);
            wst[2] = 1;
            do_op(p % 3, p % 4, 16 + (p % 8));
            do_op((p + 1) % 3, 0, 16 + (p % 8));
        end

        // Random traffic with collisions and occasional single flips
        for (int n = 0; n < 300; n++) begin
            int id, cmd, line, w;
            id   = int'($urandom % 3);
            cmd  = int'($urandom % 4);
            line = int'($urandom % 48);
            if (($urandom % 10) == 0) begin
                w = int'($urandom % 6);
                if (wst[w] == 0) begin
                    inject(w, 13'(1) << ($urandom % 13));
                    wst[w] = 1;
                end
            end
            do_op(id, cmd, line);
        end

        // R7: simultaneous bursts, two per requester
        begin
            int exp_ord [6];
            int got_n, start;
            start = (last_id + 1) % 3;
            for (int k = 0; k < 6; k++) exp_ord[k] = (start + k) % 3;
            for (int c = 0; c < 2; c++) begin
                for (int id = 0; id < 3; id++) begin
                    req_valid[id] = 1'b1;
                    req_cmd[id*2 +: 2] = 2'd0;
                    req_line[id*LINE_W +: LINE_W] = LINE_W'(64 + id * 2 + c);
                end
                @(negedge clk);
            end
            req_valid = '0;
            got_n = 0;
            for (int i = 0; i < 80; i++) begin
                if (rsp_valid && got_n < 6) begin
                    chk(int'(rsp_id) == exp_ord[got_n], "R7 order", int'(rsp_id), exp_ord[got_n]);
                    chk(rsp_code == 2'd0, "R4 burst read", int'(rsp_code), 0);
                    got_n++;
                end
                @(negedge clk);
            end
            chk(got_n == 6, "R7 count", got_n, 6);
            last_id = exp_ord[5];
        end

        // R8: backpressure from a held requester
        begin
            int acc, rsp_n;
            bit saw_low;
            acc = 0; rsp_n = 0; saw_low = 0;
            req_cmd[2 +: 2] = 2'd0;
            req_line[LINE_W +: LINE_W] = LINE_W'(70);
            req_valid[1] = 1'b1;
            for (int i = 0; i < 16; i++) begin
                if (req_ready[1]) acc++;
                else saw_low = 1;
                @(negedge clk);
                if (rsp_valid) rsp_n++;
            end
            req_valid = '0;
            for (int i = 0; i < 80; i++) begin
                @(negedge clk);
                if (rsp_valid) rsp_n++;
            end
            chk(saw_low, "R8 ready low when full", int'(saw_low), 1);
            chk(rsp_n == acc, "R8 no loss", rsp_n, acc);
            chk(req_ready == 3'b111, "R8 ready back", int'(req_ready), 7);
            last_id = 1;
        end

        // R10: double flip on word 31; R11 injection port
        do_op(0, 1, 250);
        inject(31, 13'b0000000100100);
        wst[31] = 2;
        do_op(1, 0, 250);
        do_op(2, 3, 249);
        do_op(0, 1, 7);
        do_op(2, 0, 250);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule